// File: doc/BRIEF.md
# Periodic-Tick Clock-Chip Interrupt Emulator

This block produces the three interrupt kinds of a classic real-time clock chip from one comparator channel on a free-running counter. The kinds are a periodic interrupt, an alarm and a once-per-second update. Time of day is kept elsewhere and arrives as hours, minutes and seconds inputs. The block schedules poll ticks on its comparator, at a default rate of 64 per second. On each tick it decides which of the enabled interrupt kinds are due and reports them in one flag word, which carries a one-cycle valid strobe.

Several ticks can pass unseen, for example after a large jump of the counter. In that case the comparator is stepped forward until it lies ahead of the counter again. Each extra step counts as a lost tick, and lost ticks are credited to the periodic divider. The periodic flag then keeps its average rate. A slow periodic rate (64 Hz or less) is made by dividing the poll ticks. A fast rate (above 64 Hz) shortens the tick interval instead.

Top module: `rtc_emu`

## Requirements
- R1: After reset, `chan_on_o`, `irq_valid_o`, `irq_word_o` and `cmp_o` are all zero.
- R2: When at least one enable is set and the channel is off, the next cycle shows `chan_on_o`=1 and `cmp_o` = `count_i` + delta. The value of `count_i` is taken at that edge. The delta is TICKS_PER_SEC>>`rate_sel_i` when `per_en_i`=1 and the clamped `rate_sel_i` is greater than 6. In every other case the delta is TICKS_PER_SEC>>6. `rate_sel_i` is clamped to the range 1..13, and the delta is never below 1.
- R3: While the channel is on, a tick is detected when the signed difference `count_i`−`cmp_o` is zero or positive. On a tick, `cmp_o` grows by delta. It then grows by delta again, once per cycle, while that difference stays non-negative. Each extra step counts as one lost tick, saturating at 2^LOST_W−1.
- R4: While `per_en_i`=1, each evaluated tick adds (lost ticks + 1) to a divide count. The periodic flag, bit 6 of the word, is raised once that count reaches the divide limit, and the count then returns to zero. The divide limit is 2^(6−rate) for a clamped rate of 6 or less, and 1 for a higher rate.
- R5: While `upd_en_i`=1, a tick raises the update flag, bit 4 of the word, when `sec_i` differs from the seconds value recorded at an earlier tick. The tick then records `sec_i`.
- R6: A 0→1 change of `upd_en_i` forgets the recorded seconds value. The first tick after that only records `sec_i` and raises no update flag.
- R7: While `alm_en_i`=1, a tick raises the alarm flag, bit 5 of the word, when `sec_i`, `min_i` and `hour_i` each equal `alm_sec_i`, `alm_min_i` and `alm_hour_i`.
- R8: `irq_valid_o` pulses for exactly one cycle, and only when a tick raises at least one flag. In that cycle `irq_word_o` holds the value 1 in bits [15:8], 1 in bit 7 (interrupt pending) and the raised flag bits, with bits [3:0] at zero. In all other cycles `irq_word_o` is zero.
- R9: When all three enables are zero, the next cycle shows `chan_on_o`=0, and no flag is reported while the channel is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | CNT_W | Free-running counter value |
| sec_i | input | 8 | Current seconds |
| min_i | input | 8 | Current minutes |
| hour_i | input | 8 | Current hours |
| alm_sec_i | input | 8 | Alarm seconds |
| alm_min_i | input | 8 | Alarm minutes |
| alm_hour_i | input | 8 | Alarm hours |
| per_en_i | input | 1 | Periodic interrupt enable |
| alm_en_i | input | 1 | Alarm interrupt enable |
| upd_en_i | input | 1 | Update interrupt enable |
| rate_sel_i | input | 4 | Periodic rate, log2 of Hz (1..13) |
| cmp_o | output | CNT_W | Next tick comparator value |
| chan_on_o | output | 1 | Tick channel running |
| irq_word_o | output | 16 | Flag word |
| irq_valid_o | output | 1 | Flag word strobe |

## Verification
If the scheduler state is wrong, `cmp_o` shows it on the port within one cycle of a restart or a tick: the step size or the start value is off by a delta. The lost-tick count is not visible directly. A wrong count shows up one tick late, or one tick early, as the timing of the next periodic flag. The bench therefore checks where the comparator lands after a counter jump, and in which tick the flag then arrives. A stale recorded seconds value or a wrong divide count appears only when the next flag word comes out. That can be up to one poll interval, or one divide period, after the fault.

// File: rtl/rtc_emu_pkg.sv
package rtc_emu_pkg;
    localparam logic [3:0] POLL_LOG2 = 4'd6;
    localparam logic [3:0] RATE_MIN  = 4'd1;
    localparam logic [3:0] RATE_MAX  = 4'd13;

    localparam int BIT_IRQ = 7;
    localparam int BIT_PER = 6;
    localparam int BIT_ALM = 5;
    localparam int BIT_UPD = 4;

    typedef enum logic [1:0] {
        ST_OFF   = 2'd0,
        ST_ARMED = 2'd1,
        ST_CATCH = 2'd2
    } sched_st_e;
endpackage

// File: rtl/rtc_delta_sel.sv
module rtc_delta_sel
    import rtc_emu_pkg::*;
#(
    parameter int              CNT_W         = 32,
    parameter int              DIV_W         = 10,
    parameter logic [CNT_W-1:0] TICKS_PER_SEC = 1_000_000
) (
    input  logic             per_en_i,
    input  logic [3:0]       rate_sel_i,
    output logic [CNT_W-1:0] delta_o,
    output logic [DIV_W-1:0] limit_o
);
    localparam logic [CNT_W-1:0] BASE_DELTA = TICKS_PER_SEC >> POLL_LOG2;

    logic [3:0]       rate;
    logic [CNT_W-1:0] fast_delta;
    logic             fast;

    always_comb begin
        rate = rate_sel_i;
        if (rate < RATE_MIN) begin
            rate = RATE_MIN;
        end else if (rate > RATE_MAX) begin
            rate = RATE_MAX;
        end
        fast       = (rate > POLL_LOG2);
        fast_delta = TICKS_PER_SEC >> rate;
        if (fast_delta == '0) begin
            fast_delta = {{(CNT_W-1){1'b0}}, 1'b1};
        end
        delta_o = (per_en_i && fast) ? fast_delta : BASE_DELTA;
        limit_o = fast ? DIV_W'(1) : (DIV_W'(1) << (POLL_LOG2 - rate));
    end
endmodule

// File: rtl/rtc_tick_sched.sv
module rtc_tick_sched
    import rtc_emu_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int LOST_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  count_i,
    input  logic              any_en_i,
    input  logic [CNT_W-1:0]  delta_i,
    output logic [CNT_W-1:0]  cmp_o,
    output logic              on_o,
    output logic              eval_o,
    output logic [LOST_W-1:0] lost_o
);
    typedef struct packed {
        sched_st_e        st;
        logic [CNT_W-1:0]  cmp;
        logic [LOST_W-1:0] lost;
    } sched_t;

    sched_t q, d;
    logic [CNT_W-1:0] diff;
    logic             behind;

    always_comb begin
        d      = q;
        eval_o = 1'b0;
        diff   = count_i - q.cmp;
        behind = ~diff[CNT_W-1];
        if (!any_en_i) begin
            d.st = ST_OFF;
        end else if (q.st == ST_OFF) begin
            d.st   = ST_ARMED;
            d.cmp  = count_i + delta_i;
            d.lost = '0;
        end else if (q.st == ST_ARMED) begin
            if (behind) begin
                d.st   = ST_CATCH;
                d.cmp  = q.cmp + delta_i;
                d.lost = '0;
            end
        end else begin
            if (behind) begin
                d.cmp = q.cmp + delta_i;
                if (q.lost != '1) begin
                    d.lost = q.lost + 1'b1;
                end
            end else begin
                eval_o = 1'b1;
                d.st   = ST_ARMED;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_OFF, cmp: '0, lost: '0};
        end else begin
            q <= d;
        end
    end

    assign cmp_o  = q.cmp;
    assign on_o   = (q.st != ST_OFF);
    assign lost_o = q.lost;
endmodule

// File: rtl/rtc_flag_gen.sv
module rtc_flag_gen
    import rtc_emu_pkg::*;
#(
    parameter int LOST_W = 8,
    parameter int DIV_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              eval_i,
    input  logic [LOST_W-1:0] lost_i,
    input  logic [DIV_W-1:0]  limit_i,
    input  logic              per_en_i,
    input  logic              alm_en_i,
    input  logic              upd_en_i,
    input  logic [7:0]        sec_i,
    input  logic [7:0]        min_i,
    input  logic [7:0]        hour_i,
    input  logic [7:0]        alm_sec_i,
    input  logic [7:0]        alm_min_i,
    input  logic [7:0]        alm_hour_i,
    output logic [15:0]       word_o,
    output logic              valid_o
);
    typedef struct packed {
        logic [DIV_W-1:0] div_cnt;
        logic [7:0]       prev_sec;
        logic             prev_ok;
        logic             upd_en_q;
        logic [15:0]      word;
        logic             valid;
    } flag_t;

    flag_t q, d;
    logic [DIV_W:0] sum;
    logic           ok_now, pf, af, uf;

    always_comb begin
        d          = q;
        d.upd_en_q = upd_en_i;
        d.valid    = 1'b0;
        d.word     = '0;
        pf = 1'b0;
        af = 1'b0;
        uf = 1'b0;
        sum = {1'b0, q.div_cnt} + (DIV_W+1)'(lost_i) + 1'b1;
        ok_now = (upd_en_i && !q.upd_en_q) ? 1'b0 : q.prev_ok;
        d.prev_ok = ok_now;
        if (eval_i) begin
            if (per_en_i) begin
                if (sum >= {1'b0, limit_i}) begin
                    pf        = 1'b1;
                    d.div_cnt = '0;
                end else begin
                    d.div_cnt = sum[DIV_W-1:0];
                end
            end
            if (upd_en_i && (!ok_now || sec_i != q.prev_sec)) begin
                uf         = ok_now;
                d.prev_sec = sec_i;
                d.prev_ok  = 1'b1;
            end
            af = alm_en_i && (sec_i == alm_sec_i) && (min_i == alm_min_i)
                 && (hour_i == alm_hour_i);
            if (pf || af || uf) begin
                d.valid            = 1'b1;
                d.word[15:8]       = 8'd1;
                d.word[BIT_IRQ]    = 1'b1;
                d.word[BIT_PER]    = pf;
                d.word[BIT_ALM]    = af;
                d.word[BIT_UPD]    = uf;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign word_o  = q.word;
    assign valid_o = q.valid;
endmodule

// File: rtl/rtc_emu.sv
module rtc_emu
    import rtc_emu_pkg::*;
#(
    parameter int               CNT_W         = 32,
    parameter int               LOST_W        = 8,
    parameter int               DIV_W         = 10,
    parameter logic [CNT_W-1:0] TICKS_PER_SEC = 1_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] count_i,
    input  logic [7:0]       sec_i,
    input  logic [7:0]       min_i,
    input  logic [7:0]       hour_i,
    input  logic [7:0]       alm_sec_i,
    input  logic [7:0]       alm_min_i,
    input  logic [7:0]       alm_hour_i,
    input  logic             per_en_i,
    input  logic             alm_en_i,
    input  logic             upd_en_i,
    input  logic [3:0]       rate_sel_i,
    output logic [CNT_W-1:0] cmp_o,
    output logic             chan_on_o,
    output logic [15:0]      irq_word_o,
    output logic             irq_valid_o
);
    logic [CNT_W-1:0]  tick_delta;
    logic [DIV_W-1:0]  div_limit;
    logic              tick_eval;
    logic [LOST_W-1:0] tick_lost;
    logic              any_en;

    assign any_en = per_en_i | alm_en_i | upd_en_i;

    rtc_delta_sel #(
        .CNT_W(CNT_W), .DIV_W(DIV_W), .TICKS_PER_SEC(TICKS_PER_SEC)
    ) u_delta (
        .per_en_i  (per_en_i),
        .rate_sel_i(rate_sel_i),
        .delta_o   (tick_delta),
        .limit_o   (div_limit)
    );

    rtc_tick_sched #(.CNT_W(CNT_W), .LOST_W(LOST_W)) u_sched (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_i (count_i),
        .any_en_i(any_en),
        .delta_i (tick_delta),
        .cmp_o   (cmp_o),
        .on_o    (chan_on_o),
        .eval_o  (tick_eval),
        .lost_o  (tick_lost)
    );

    rtc_flag_gen #(.LOST_W(LOST_W), .DIV_W(DIV_W)) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .eval_i    (tick_eval),
        .lost_i    (tick_lost),
        .limit_i   (div_limit),
        .per_en_i  (per_en_i),
        .alm_en_i  (alm_en_i),
        .upd_en_i  (upd_en_i),
        .sec_i     (sec_i),
        .min_i     (min_i),
        .hour_i    (hour_i),
        .alm_sec_i (alm_sec_i),
        .alm_min_i (alm_min_i),
        .alm_hour_i(alm_hour_i),
        .word_o    (irq_word_o),
        .valid_o   (irq_valid_o)
    );
endmodule

// File: rtl/rtc_emu_chk.sv
module rtc_emu_chk #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] count_i,
    input logic [7:0]       sec_i,
    input logic [7:0]       min_i,
    input logic [7:0]       hour_i,
    input logic [7:0]       alm_sec_i,
    input logic [7:0]       alm_min_i,
    input logic [7:0]       alm_hour_i,
    input logic             per_en_i,
    input logic             alm_en_i,
    input logic             upd_en_i,
    input logic [CNT_W-1:0] cmp_o,
    input logic             chan_on_o,
    input logic [15:0]      irq_word_o,
    input logic             irq_valid_o,
    input logic [CNT_W-1:0] delta_i
);
    logic any_en, alm_hit;
    assign any_en  = per_en_i | alm_en_i | upd_en_i;
    assign alm_hit = alm_en_i && (sec_i == alm_sec_i) && (min_i == alm_min_i)
                     && (hour_i == alm_hour_i);

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!chan_on_o && !irq_valid_o && cmp_o == '0));

    p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_on_o && any_en) |=>
        (chan_on_o && cmp_o == $past(count_i) + $past(delta_i)));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_on_o && $past(chan_on_o) && cmp_o != $past(cmp_o)) |->
        (cmp_o - $past(cmp_o) == $past(delta_i)));

    p_pf_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && irq_word_o[6]) |-> $past(per_en_i));

    p_af_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid_o && irq_word_o[5]) |-> $past(alm_hit));

    p_word_form_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |-> (irq_word_o[15:8] == 8'd1 && irq_word_o[7]
                         && irq_word_o[6:4] != 3'd0 && irq_word_o[3:0] == 4'd0));

    p_one_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid_o |=> !irq_valid_o);

    p_off_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !any_en |=> !chan_on_o);

    p_off_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_on_o |-> !irq_valid_o);
endmodule

bind rtc_emu rtc_emu_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .count_i    (count_i),
    .sec_i      (sec_i),
    .min_i      (min_i),
    .hour_i     (hour_i),
    .alm_sec_i  (alm_sec_i),
    .alm_min_i  (alm_min_i),
    .alm_hour_i (alm_hour_i),
    .per_en_i   (per_en_i),
    .alm_en_i   (alm_en_i),
    .upd_en_i   (upd_en_i),
    .cmp_o      (cmp_o),
    .chan_on_o  (chan_on_o),
    .irq_word_o (irq_word_o),
    .irq_valid_o(irq_valid_o),
    .delta_i    (tick_delta)
);

// File: tb/sim_rtc_emu.sv
`timescale 1ns/1ps
module sim_rtc_emu;
    localparam logic [31:0] TPS  = 32'd4096;
    localparam int          BASE = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cnt = '0;
    logic [31:0] step = 32'd1;
    logic [7:0]  sec = '0, mnt = '0, hr = '0;
    logic [7:0]  a_sec = 8'd3, a_min = 8'd2, a_hr = 8'd1;
    logic        per_en = 1'b0, alm_en = 1'b0, upd_en = 1'b0;
    logic [3:0]  rate = 4'd6;
    logic [31:0] cmp;
    logic        chan_on;
    logic [15:0] word;
    logic        valid;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;
    always @(posedge clk) begin
        cnt <= cnt + step;
        cyc <= cyc + 1;
    end

    rtc_emu #(.TICKS_PER_SEC(TPS)) u0 (
        .clk(clk), .rst_n(rst_n), .count_i(cnt),
        .sec_i(sec), .min_i(mnt), .hour_i(hr),
        .alm_sec_i(a_sec), .alm_min_i(a_min), .alm_hour_i(a_hr),
        .per_en_i(per_en), .alm_en_i(alm_en), .upd_en_i(upd_en),
        .rate_sel_i(rate), .cmp_o(cmp), .chan_on_o(chan_on),
        .irq_word_o(word), .irq_valid_o(valid)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_valid(input int n, output bit found, output logic [15:0] w,
                              output logic [31:0] c, output int at);
        found = 1'b0; w = '0; c = '0; at = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (valid) begin
                found = 1'b1; w = word; c = cmp; at = cyc;
                return;
            end
        end
    endtask

    task automatic all_off();
        @(negedge clk);
        per_en = 1'b0; alm_en = 1'b0; upd_en = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        check(cmp == 0, "R1", "cmp after reset", cmp, 0);
        check(!chan_on, "R1", "chan_on after reset", chan_on, 0);
        check(!valid, "R1", "valid after reset", valid, 0);
        check(word == 0, "R1", "word after reset", word, 0);
    endtask

    task automatic restart_check(input bit p, input bit a, input logic [3:0] r,
                                 input int exp_delta, input string tag);
        logic [31:0] c0;
        all_off();
        rate = r; per_en = p; alm_en = a; c0 = cnt;
        @(negedge clk);
        check(chan_on, "R2", {tag, " chan_on"}, chan_on, 1);
        check(cmp == c0 + exp_delta, "R2", {tag, " cmp"}, cmp, c0 + exp_delta);
    endtask

    task automatic t_restart();
        restart_check(1'b0, 1'b1, 4'd7, BASE, "alarm only");
        restart_check(1'b1, 1'b0, 4'd7, 32, "fast periodic");
        restart_check(1'b1, 1'b0, 4'd3, BASE, "slow periodic");
        restart_check(1'b1, 1'b0, 4'd15, 1, "clamped rate 13");
        restart_check(1'b1, 1'b0, 4'd0, BASE, "clamped rate 1");
    endtask

    task automatic t_periodic();
        bit f; logic [15:0] w; logic [31:0] c; int t1, t2, t3;
        all_off();
        rate = 4'd5; per_en = 1'b1;
        wait_valid(400, f, w, c, t1);
        check(f && w == 16'h01C0, "R4", "periodic word 32Hz", w, 16'h01C0);
        wait_valid(400, f, w, c, t2);
        check(f && (t2 - t1) == 2 * BASE, "R4", "32Hz interval", t2 - t1, 2 * BASE);
        rate = 4'd7;
        wait_valid(400, f, w, c, t1);
        wait_valid(400, f, w, c, t2);
        wait_valid(400, f, w, c, t3);
        check(f && (t3 - t2) == 32, "R4", "128Hz interval", t3 - t2, 32);
    endtask

    task automatic t_lost();
        bit f; logic [15:0] w; logic [31:0] c; int t; logic [31:0] c0;
        all_off();
        rate = 4'd4; per_en = 1'b1; c0 = cnt;
        @(negedge clk); step = 32'd200;
        @(negedge clk); step = 32'd1;
        repeat (10) @(negedge clk);
        check(cmp == c0 + 4 * BASE, "R3", "cmp after catch-up", cmp - c0, 4 * BASE);
        check(!valid, "R4", "no flag on lost-tick credit", valid, 0);
        wait_valid(300, f, w, c, t);
        check(f && w == 16'h01C0, "R4", "periodic word after loss", w, 16'h01C0);
        check(f && c == c0 + 5 * BASE, "R4", "flag tick after loss", c - c0, 5 * BASE);
    endtask

    task automatic t_update();
        bit f; logic [15:0] w; logic [31:0] c; int t;
        all_off();
        sec = 8'd10; upd_en = 1'b1;
        wait_valid(150, f, w, c, t);
        check(!f, "R6", "first tick records only", f, 0);
        sec = 8'd11;
        wait_valid(150, f, w, c, t);
        check(f && w == 16'h0190, "R5", "update word", w, 16'h0190);
        wait_valid(200, f, w, c, t);
        check(!f, "R5", "no update when seconds steady", f, 0);
        all_off();
        sec = 8'd20; upd_en = 1'b1;
        wait_valid(150, f, w, c, t);
        check(!f, "R6", "re-enable forgets seconds", f, 0);
        sec = 8'd21;
        wait_valid(150, f, w, c, t);
        check(f && w == 16'h0190, "R5", "update after re-enable", w, 16'h0190);
    endtask

    task automatic t_alarm();
        bit f; logic [15:0] w; logic [31:0] c; int t;
        all_off();
        a_hr = 8'd12; a_min = 8'd34; a_sec = 8'd56;
        hr = 8'd12; mnt = 8'd34; sec = 8'd55; alm_en = 1'b1;
        wait_valid(150, f, w, c, t);
        check(!f, "R7", "seconds mismatch", f, 0);
        hr = 8'd13; sec = 8'd56;
        wait_valid(150, f, w, c, t);
        check(!f, "R7", "hours mismatch", f, 0);
        hr = 8'd12;
        wait_valid(150, f, w, c, t);
        check(f && w == 16'h01A0, "R7", "alarm word", w, 16'h01A0);
        rate = 4'd7; per_en = 1'b1;
        repeat (2) @(negedge clk);
        wait_valid(150, f, w, c, t);
        check(f && w == 16'h01E0, "R8", "combined word", w, 16'h01E0);
        @(negedge clk);
        check(!valid && word == 0, "R8", "word cleared after pulse", word, 0);
    endtask

    task automatic t_disable();
        bit f; logic [15:0] w; logic [31:0] c; int t;
        @(negedge clk);
        per_en = 1'b0; alm_en = 1'b0; upd_en = 1'b0;
        @(negedge clk);
        check(!chan_on, "R9", "channel off", chan_on, 0);
        wait_valid(300, f, w, c, t);
        check(!f, "R9", "no flags while off", f, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_restart();
        t_periodic();
        t_lost();
        t_update();
        t_alarm();
        t_disable();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule